// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent page translations so that a 32-bit virtual address can be turned into a physical address without walking the page table. The page size is 4 KB. The upper 20 bits of the virtual address (the page number) and a process tag are compared against every entry in parallel. The lower 12 bits, the offset within the page, pass through unchanged. A lookup resolves combinationally in the cycle it is presented. Any bookkeeping that the lookup causes (the use mark and the modified mark) is stored at the next clock edge.

When no entry matches, the block raises a miss so that a handler can walk the page table. The handler then installs the translation through the refill port. A write that matches an entry without write permission raises a protection fault. Because each entry carries the tag of the process that owns it, a context switch needs no flush. A single-cycle flush input still empties the whole buffer.

Replacement follows an approximation of least-recently-used. Every entry has a use mark that is set whenever a lookup hits it. A free-running timer wipes all use marks at a fixed interval. On refill, the new entry goes to the first empty slot. If there is no empty slot, it goes to the first slot whose use mark is clear. If every use mark is set, it goes to slot 0.

Top module: `tlb_fa`

## Requirements
- R1: A lookup that hits drives `lk_paddr` = {stored physical page number, `lk_vaddr[11:0]`} in the same cycle, with `lk_hit` high.
- R2: A lookup with no valid entry matching both the page number `lk_vaddr[31:12]` and `lk_pid` drives `lk_miss` high, `lk_hit` low and `lk_paddr` zero.
- R3: An entry whose page number matches but whose process tag differs from `lk_pid` does not hit.
- R4: A write lookup (`lk_write`=1) that hits an entry installed with `fill_writable`=0 drives `lk_prot_fault` high together with `lk_hit`, and leaves that entry's modified mark clear.
- R5: A write lookup that hits a writable entry shows the old modified mark on `lk_dirty` in that cycle and sets the mark at the clock edge, so later lookups of that page show `lk_dirty`=1.
- R6: A refill writes the lowest-numbered empty slot when one exists. The new entry starts with clear modified and use marks.
- R7: With no empty slot, a refill replaces the lowest-numbered slot whose use mark is clear. If all use marks are set, it replaces slot 0.
- R8: Any hitting lookup sets that entry's use mark. Every REF_PERIOD cycles after reset, all use marks are cleared, and the clear takes precedence over a hit in the same cycle.
- R9: `flush_all` empties every slot at one clock edge. A refill presented in the same cycle is dropped.
- R10: After reset, every slot is empty and a lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is for a store |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | 8 | Process tag of the requester |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Lookup found no translation |
| lk_prot_fault | output | 1 | Store to a read-only page |
| lk_dirty | output | 1 | Modified mark of the hitting entry before this access |
| lk_paddr | output | 32 | Translated physical address, zero when no hit |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Page number to install |
| fill_pid | input | 8 | Process tag to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_writable | input | 1 | Page may be written |
| flush_all | input | 1 | Empty every slot |

## Verification
A corrupted tag or valid bit shows up in the same cycle as a wrong hit or a wrong miss on the next lookup of that page. A lost modified mark shows up only on the following lookup of the page. A wrong use mark or a wrong victim choice cannot be seen directly at the ports. It appears only after a later refill, when one specific earlier page begins to miss while its neighbours still hit. The bench therefore reads eviction outcomes back through lookups. It also places one refill after a full timer interval, so that a timer which never clears the marks evicts a different slot than expected.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // How the refill slot was chosen
  typedef enum logic [1:0] {
    VS_INVALID  = 2'd0,
    VS_UNREF    = 2'd1,
    VS_FALLBACK = 2'd2
  } vsel_t;
endpackage

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  // lowest set bit wins: scan from the top down so the last assignment is the lowest
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PID_W = 8
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][VPN_W-1:0] vpn_q,
  input  logic [N-1:0][PID_W-1:0] pid_q,
  input  logic [VPN_W-1:0]        vpn,
  input  logic [PID_W-1:0]        pid,
  output logic [N-1:0]            match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (vpn_q[g] == vpn) && (pid_q[g] == pid);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  valid,
  input  logic [N-1:0]  refd,
  output logic [IW-1:0] vic_idx,
  output vsel_t         vic_sel
);
  logic [IW-1:0] inv_idx, unref_idx;
  logic          inv_any, unref_any;

  tlb_prio #(.N(N), .IW(IW)) u_inv   (.vec(~valid), .idx(inv_idx),   .any(inv_any));
  tlb_prio #(.N(N), .IW(IW)) u_unref (.vec(~refd & valid), .idx(unref_idx), .any(unref_any));

  always_comb begin
    if (inv_any) begin
      vic_idx = inv_idx;
      vic_sel = VS_INVALID;
    end else if (unref_any) begin
      vic_idx = unref_idx;
      vic_sel = VS_UNREF;
    end else begin
      vic_idx = '0;
      vic_sel = VS_FALLBACK;
    end
  end
endmodule

// File: rtl/tlb_ref_timer.sv
module tlb_ref_timer #(
  parameter int PERIOD = 1024,
  parameter int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic clr
);
  logic [CW-1:0] cnt;

  assign clr = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int VA_W       = 32,
  parameter int OFF_W      = 12,
  parameter int PPN_W      = 20,
  parameter int PID_W      = 8,
  parameter int REF_PERIOD = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic                   lk_write,
  input  logic [VA_W-1:0]        lk_vaddr,
  input  logic [PID_W-1:0]       lk_pid,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic                   lk_prot_fault,
  output logic                   lk_dirty,
  output logic [PPN_W+OFF_W-1:0] lk_paddr,
  input  logic                   fill_en,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn,
  input  logic [PID_W-1:0]       fill_pid,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic                   fill_writable,
  input  logic                   flush_all
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // entry storage, one bit vector per flag
  logic [ENTRIES-1:0]            valid_q, dirty_q, wr_q, ref_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PID_W-1:0] pid_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;

  // named internal events, observed by the checker
  logic [ENTRIES-1:0] match_vec;
  logic [IW-1:0]      hit_idx, vic_idx;
  logic               hit_any, wr_ok, ref_clr, fill_go;
  vsel_t              vic_sel;

  function automatic logic [PA_W-1:0] join_paddr(input logic [PPN_W-1:0] ppn,
                                                  input logic [VA_W-1:0]  va);
    return {ppn, va[OFF_W-1:0]};
  endfunction

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_match (
    .valid (valid_q),
    .vpn_q (vpn_q),
    .pid_q (pid_q),
    .vpn   (lk_vaddr[VA_W-1:OFF_W]),
    .pid   (lk_pid),
    .match (match_vec)
  );

  tlb_prio #(.N(ENTRIES), .IW(IW)) u_hitsel (
    .vec (match_vec),
    .idx (hit_idx),
    .any (hit_any)
  );

  tlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .valid   (valid_q),
    .refd    (ref_q),
    .vic_idx (vic_idx),
    .vic_sel (vic_sel)
  );

  tlb_ref_timer #(.PERIOD(REF_PERIOD)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ref_clr)
  );

  assign lk_hit        = lk_valid && hit_any;
  assign lk_miss       = lk_valid && !hit_any;
  assign lk_prot_fault = lk_hit && lk_write && !wr_q[hit_idx];
  assign wr_ok         = lk_hit && lk_write && wr_q[hit_idx];
  assign lk_dirty      = lk_hit && dirty_q[hit_idx];
  assign lk_paddr      = lk_hit ? join_paddr(ppn_q[hit_idx], lk_vaddr) : '0;
  assign fill_go       = fill_en && !flush_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      wr_q    <= '0;
      ref_q   <= '0;
      vpn_q   <= '0;
      pid_q   <= '0;
      ppn_q   <= '0;
    end else begin
      // use marks: periodic clear dominates, otherwise a hit marks its entry
      if (ref_clr)     ref_q <= '0;
      else if (lk_hit) ref_q[hit_idx] <= 1'b1;

      if (wr_ok) dirty_q[hit_idx] <= 1'b1;

      if (flush_all) begin
        valid_q <= '0;
      end else if (fill_go) begin
        valid_q[vic_idx] <= 1'b1;
        vpn_q[vic_idx]   <= fill_vpn;
        pid_q[vic_idx]   <= fill_pid;
        ppn_q[vic_idx]   <= fill_ppn;
        wr_q[vic_idx]    <= fill_writable;
        dirty_q[vic_idx] <= 1'b0;
        ref_q[vic_idx]   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk
  import tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IW    = 4,
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic            lk_write,
  input logic            lk_hit,
  input logic            lk_miss,
  input logic            lk_prot_fault,
  input logic [VA_W-1:0] lk_vaddr,
  input logic [PA_W-1:0] lk_paddr,
  input logic            flush_all,
  input logic            fill_go,
  input logic            ref_clr,
  input logic            wr_ok,
  input logic [IW-1:0]   hit_idx,
  input logic [IW-1:0]   vic_idx,
  input vsel_t           vic_sel,
  input logic [N-1:0]    valid_vec,
  input logic [N-1:0]    ref_vec,
  input logic [N-1:0]    dirty_vec
);
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);  // R1
  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit ^ lk_miss));  // R2
  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_vec == '0) |-> !lk_hit);  // R2
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_prot_fault |-> (lk_hit && lk_write && !wr_ok));  // R4
  AST_DIRTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !(fill_go && vic_idx == hit_idx)) |=> dirty_vec[$past(hit_idx)]);  // R5
  AST_VICTIM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_sel == VS_INVALID) |-> !valid_vec[vic_idx]);  // R6
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> valid_vec[$past(vic_idx)]);  // R6
  AST_FALLBACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_sel == VS_FALLBACK) |-> (vic_idx == '0 && ref_vec == '1));  // R7
  AST_REF_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clr |=> (ref_vec == '0));  // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));  // R9
endmodule

bind tlb_fa tlb_fa_chk #(
  .N(ENTRIES), .IW(IW), .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_valid      (lk_valid),
  .lk_write      (lk_write),
  .lk_hit        (lk_hit),
  .lk_miss       (lk_miss),
  .lk_prot_fault (lk_prot_fault),
  .lk_vaddr      (lk_vaddr),
  .lk_paddr      (lk_paddr),
  .flush_all     (flush_all),
  .fill_go       (fill_go),
  .ref_clr       (ref_clr),
  .wr_ok         (wr_ok),
  .hit_idx       (hit_idx),
  .vic_idx       (vic_idx),
  .vic_sel       (vic_sel),
  .valid_vec     (valid_q),
  .ref_vec       (ref_q),
  .dirty_vec     (dirty_q)
);

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD_REF = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_pid = '0;
  logic        lk_hit, lk_miss, lk_prot_fault, lk_dirty;
  logic [31:0] lk_paddr;
  logic        fill_en = 1'b0, fill_writable = 1'b0, flush_all = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [7:0]  fill_pid = '0;

  int checks = 0;
  int errors = 0;

  // values captured by the lookup task
  logic s_hit, s_miss, s_fault, s_dirty;
  logic [31:0] s_paddr;

  tlb_fa #(.REF_PERIOD(PERIOD_REF)) dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_prot_fault(lk_prot_fault),
    .lk_dirty(lk_dirty), .lk_paddr(lk_paddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_ppn(fill_ppn),
    .fill_writable(fill_writable), .flush_all(flush_all)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] pid, input logic wr);
    @(negedge clk);
    lk_valid = 1'b1; lk_write = wr; lk_vaddr = va; lk_pid = pid;
    #2;
    s_hit = lk_hit; s_miss = lk_miss; s_fault = lk_prot_fault;
    s_dirty = lk_dirty; s_paddr = lk_paddr;
    @(posedge clk);
    #1 lk_valid = 1'b0; lk_write = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] pid,
                      input logic [19:0] ppn, input logic wr, input logic fl);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_pid = pid; fill_ppn = ppn;
    fill_writable = wr; flush_all = fl;
    @(posedge clk);
    #1 fill_en = 1'b0; flush_all = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [19:0] vpn, input logic [7:0] pid,
                            input logic [19:0] ppn);
    lookup({vpn, 12'h3A5}, pid, 1'b0);
    check(req, "hit", {31'd0, s_hit}, 32'd1);
    check(req, "paddr", s_paddr, {ppn, 12'h3A5});
  endtask

  task automatic expect_miss(input string req, input logic [19:0] vpn, input logic [7:0] pid);
    lookup({vpn, 12'h010}, pid, 1'b0);
    check(req, "miss", {31'd0, s_miss}, 32'd1);
    check(req, "hit", {31'd0, s_hit}, 32'd0);
    check(req, "paddr zero", s_paddr, 32'd0);
  endtask

  task automatic t_reset_state();
    do_reset();
    expect_miss("R10", 20'h12345, 8'd1);
  endtask

  task automatic t_translate();
    fill(20'h12345, 8'd1, 20'hABCDE, 1'b1, 1'b0);
    lookup(32'h12345678, 8'd1, 1'b0);
    check("R1", "hit", {31'd0, s_hit}, 32'd1);
    check("R1", "paddr", s_paddr, 32'hABCDE678);
    lookup(32'h12345FFF, 8'd1, 1'b0);
    check("R1", "paddr top offset", s_paddr, 32'hABCDEFFF);
    expect_miss("R3", 20'h12345, 8'd2);
    expect_miss("R2", 20'h12346, 8'd1);
  endtask

  task automatic t_dirty();
    lookup(32'h12345004, 8'd1, 1'b1);
    check("R5", "write hit", {31'd0, s_hit}, 32'd1);
    check("R5", "no fault", {31'd0, s_fault}, 32'd0);
    check("R5", "old dirty", {31'd0, s_dirty}, 32'd0);
    lookup(32'h12345008, 8'd1, 1'b0);
    check("R5", "dirty now set", {31'd0, s_dirty}, 32'd1);
  endtask

  task automatic t_protect();
    fill(20'h00777, 8'd1, 20'h00042, 1'b0, 1'b0);
    lookup(32'h00777100, 8'd1, 1'b1);
    check("R4", "fault", {31'd0, s_fault}, 32'd1);
    check("R4", "hit with fault", {31'd0, s_hit}, 32'd1);
    lookup(32'h00777100, 8'd1, 1'b0);
    check("R4", "dirty stays clear", {31'd0, s_dirty}, 32'd0);
    check("R4", "read no fault", {31'd0, s_fault}, 32'd0);
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush_all = 1'b1;
    @(posedge clk);
    #1 flush_all = 1'b0;
    expect_miss("R9", 20'h12345, 8'd1);
    fill(20'h55555, 8'd3, 20'h11111, 1'b1, 1'b1);
    expect_miss("R9", 20'h55555, 8'd3);
  endtask

  // slot i holds vpn 0x100+i after this fill sequence
  task automatic t_replace();
    do_reset();
    for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 8'd7, 20'h80000 + 20'(i), 1'b1, 1'b0);
    for (int i = 0; i < 16; i++) expect_hit("R6", 20'h00100 + 20'(i), 8'd7, 20'h80000 + 20'(i));
    // every slot was just hit; restart from a known point
    do_reset();
    for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 8'd7, 20'h80000 + 20'(i), 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) lookup({20'h00100 + 20'(i), 12'h0}, 8'd7, 1'b0);
    fill(20'h00200, 8'd7, 20'h90000, 1'b1, 1'b0);
    expect_miss("R7", 20'h00105, 8'd7);
    expect_hit("R7", 20'h00106, 8'd7, 20'h80006);
    expect_hit("R7", 20'h00100, 8'd7, 20'h80000);
    expect_hit("R7", 20'h00200, 8'd7, 20'h90000);
    // mark the remaining slots 7..15 so every use mark is set
    for (int i = 7; i < 16; i++) lookup({20'h00100 + 20'(i), 12'h0}, 8'd7, 1'b0);
    fill(20'h00300, 8'd7, 20'hA0000, 1'b1, 1'b0);
    expect_miss("R7", 20'h00100, 8'd7);
    expect_hit("R7", 20'h00300, 8'd7, 20'hA0000);
    // let the periodic clear run, then mark slot 0 only
    repeat (PERIOD_REF) @(negedge clk);
    lookup({20'h00300, 12'h0}, 8'd7, 1'b0);
    fill(20'h00400, 8'd7, 20'hB0000, 1'b1, 1'b0);
    expect_miss("R8", 20'h00101, 8'd7);
    expect_hit("R8", 20'h00300, 8'd7, 20'hA0000);
    expect_hit("R8", 20'h00400, 8'd7, 20'hB0000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_translate();
    t_dirty();
    t_protect();
    t_flush();
    t_replace();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule